// File: doc/BRIEF.md
# Serial Link Packet Deframer

This block sits behind the receive side of a character-coded serial link. Every clock it takes one 16-bit halfword together with two flags that mark each byte as a control character or as ordinary data. From that stream it recovers packets and joins pairs of halfwords back into 32-bit words. It marks the first and last word of each packet and checks the 16-bit CRC that trails every packet. Flow-control characters and link fault codes are reported on their own outputs. They never disturb the packet in progress.

Recovered words leave through a single output register with a valid/ready handshake. The last word of each packet carries a flag that reports a CRC mismatch or an aborted packet. Because the end of a packet is only known once the end marker and the CRC halfword have arrived, the block holds the most recent word back in a pending register until it knows whether that word is the last one.

Top module: `link_deframer`

## Requirements
- R1: After reset, out_valid, xon_rcvd, xoff_rcvd and link_error are 0, and the block hunts for a packet start.
- R2: A start halfword (both flags set, both bytes 0xDC) opens a packet. Each following pair of plain data halfwords (both flags clear) forms one word, with the first halfword as bits [15:0] and the second as bits [31:16]. The first word of a packet has out_sop=1.
- R3: An idle halfword (high byte flagged 0xBC, low byte unflagged 0xC5) is discarded wherever it appears. It changes neither word assembly nor the CRC.
- R4: An end halfword (both flags set, both bytes 0x9C) after a complete word is followed by a plain CRC halfword. The last word is then delivered with out_eop=1. out_crc_err=0 when the CRC halfword equals the CRC computed over the payload halfwords in arrival order. That CRC starts at 0xFFFF, uses polynomial 0x1021 and takes each halfword MSB first.
- R5: When the CRC halfword differs from the computed value, the last word carries out_eop=1 and out_crc_err=1.
- R6: An XON halfword (both flags set, both bytes 0x5C) gives a one-cycle pulse on xon_rcvd in the cycle after it is sampled. An XOFF halfword (both bytes 0x7C) does the same on xoff_rcvd. Neither changes the packet in progress.
- R7: Any of the following aborts the current packet: an end halfword after only a low half, a start halfword inside a packet, a fault byte inside a packet, or any other unrecognised control halfword inside a packet. On an abort, the pending word is delivered with out_eop=1 and out_crc_err=1, and the block returns to hunting.
- R8: A flagged byte of 0x00 or 0xFF, in either byte position, sets link_error. link_error stays set until err_clear is high in a cycle with no new fault, and a new fault wins over err_clear.
- R9: While hunting, data and end halfwords produce no output.
- R10: While out_valid=1 and out_ready=0, out_valid stays high and out_data, out_sop, out_eop and out_crc_err hold their values.
- R11: A packet with no payload words produces no output.
- R12: A word that is ready for delivery while the output register is still full and not being accepted is dropped, and this sets link_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_half | input | 16 | Received halfword, high byte in [15:8] |
| rx_k_lo | input | 1 | Low byte is a control character |
| rx_k_hi | input | 1 | High byte is a control character |
| err_clear | input | 1 | Clears the sticky link_error |
| out_ready | input | 1 | Consumer accepts the output word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 32 | Recovered payload word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_crc_err | output | 1 | Packet failed its CRC or was aborted (valid with out_eop) |
| xon_rcvd | output | 1 | One-cycle pulse per XON halfword |
| xoff_rcvd | output | 1 | One-cycle pulse per XOFF halfword |
| link_error | output | 1 | Sticky fault/overrun indication |

## Verification
The embedded assertions watch several properties on every cycle:
- the output register holds its word while it is stalled;
- the error flag appears only on a last word;
- the CRC restarts at 0xFFFF on every start;
- flow-control characters never move the framing state;
- a pulse on xon_rcvd or xoff_rcvd always traces back to its character;
- link_error is sticky.

Other behaviour depends on whole frames and only the directed scenarios can show it: the low-half-first word order, the discarding of idles inside packets, the CRC verdicts on good and corrupted frames, each kind of abort, silence while hunting, empty packets, and dropped words under backpressure.

// File: rtl/lnk_deframer_pkg.sv
// Package: shared character codes and enumerations for the link deframer.
// Assumes 8-bit characters and two characters per halfword.
package lnk_deframer_pkg;
    localparam int CHAR_W = 8;

    localparam logic [CHAR_W-1:0] CH_COMMA  = 8'hBC;
    localparam logic [CHAR_W-1:0] CH_IDLE_D = 8'hC5;
    localparam logic [CHAR_W-1:0] CH_START  = 8'hDC;
    localparam logic [CHAR_W-1:0] CH_END    = 8'h9C;
    localparam logic [CHAR_W-1:0] CH_XON    = 8'h5C;
    localparam logic [CHAR_W-1:0] CH_XOFF   = 8'h7C;
    localparam logic [CHAR_W-1:0] CH_FAULT  = 8'h00;
    localparam logic [CHAR_W-1:0] CH_NOSIG  = 8'hFF;

    typedef enum logic [2:0] {
        HC_DATA, HC_IDLE, HC_START, HC_END, HC_XON, HC_XOFF, HC_BAD, HC_OTHER
    } hw_class_e;

    typedef enum logic [1:0] {
        ST_HUNT, ST_LOW, ST_HIGH, ST_CRC
    } rx_state_e;
endpackage

// File: rtl/lnk_char_decode.sv
// Module: classifies one received halfword by its two characters and flags.
// Assumes the high character sits in the upper byte. Purely combinational.
module lnk_char_decode
    import lnk_deframer_pkg::*;
#(
    parameter int HALF_W = 2*CHAR_W
) (
    input  logic [HALF_W-1:0] half,
    input  logic              k_lo,
    input  logic              k_hi,
    output hw_class_e         cls
);
    logic [CHAR_W-1:0] ch_lo, ch_hi;
    logic              fault_lo, fault_hi;

    assign ch_lo = half[CHAR_W-1:0];
    assign ch_hi = half[HALF_W-1:CHAR_W];

    // Fault detection: a flagged byte carrying an invalid code.
    assign fault_lo = k_lo && (ch_lo == CH_FAULT || ch_lo == CH_NOSIG);
    assign fault_hi = k_hi && (ch_hi == CH_FAULT || ch_hi == CH_NOSIG);

    // Classification with faults taking priority over every other pattern.
    always_comb begin
        if (fault_lo || fault_hi) begin
            cls = HC_BAD;
        end else if (!k_lo && !k_hi) begin
            cls = HC_DATA;
        end else if (k_hi && !k_lo && ch_hi == CH_COMMA && ch_lo == CH_IDLE_D) begin
            cls = HC_IDLE;
        end else if (k_hi && k_lo && ch_hi == ch_lo) begin
            case (ch_hi)
                CH_START: cls = HC_START;
                CH_END:   cls = HC_END;
                CH_XON:   cls = HC_XON;
                CH_XOFF:  cls = HC_XOFF;
                default:  cls = HC_OTHER;
            endcase
        end else begin
            cls = HC_OTHER;
        end
    end
endmodule

// File: rtl/lnk_crc16.sv
// Module: 16-bit CRC register updated with a whole halfword per cycle.
// Assumes halfwords are fed MSB first; restart has priority over update.
module lnk_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h1021,
    parameter logic [15:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             update,
    input  logic [CRC_W-1:0] din,
    output logic [CRC_W-1:0] crc_q
);
    // Unrolled bit-serial step over all input bits, MSB first.
    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                  input logic [CRC_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int b = CRC_W-1; b >= 0; b--) begin
            fb = r[CRC_W-1] ^ d[b];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return r;
    endfunction

    // CRC state register.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= INIT;
        else if (restart) crc_q <= INIT;
        else if (update)  crc_q <= crc_next(crc_q, din);
    end
endmodule

// File: rtl/lnk_frame_fsm.sv
// Module: framing state machine. Tracks packet position, assembles the low
// half of each word and signals word completion, CRC arrival and aborts.
// Assumes the halfword class comes from lnk_char_decode in the same cycle.
module lnk_frame_fsm
    import lnk_deframer_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2*HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hw_class_e         cls,
    input  logic [HALF_W-1:0] half,
    output logic              start_pkt,
    output logic              crc_update,
    output logic              word_done,
    output logic [WORD_W-1:0] word_data,
    output logic              crc_seen,
    output logic              abort
);
    rx_state_e         state, state_nxt;
    logic [HALF_W-1:0] lo_hold;

    // Next-state and event decode for the current halfword.
    always_comb begin
        state_nxt  = state;
        start_pkt  = 1'b0;
        crc_update = 1'b0;
        word_done  = 1'b0;
        crc_seen   = 1'b0;
        abort      = 1'b0;
        case (state)
            ST_HUNT: begin
                if (cls == HC_START) begin
                    start_pkt = 1'b1;
                    state_nxt = ST_LOW;
                end
            end
            ST_LOW: begin
                case (cls)
                    HC_DATA: begin
                        crc_update = 1'b1;
                        state_nxt  = ST_HIGH;
                    end
                    HC_END: state_nxt = ST_CRC;
                    HC_START, HC_BAD, HC_OTHER: begin
                        abort     = 1'b1;
                        state_nxt = ST_HUNT;
                    end
                    default: ;
                endcase
            end
            ST_HIGH: begin
                case (cls)
                    HC_DATA: begin
                        crc_update = 1'b1;
                        word_done  = 1'b1;
                        state_nxt  = ST_LOW;
                    end
                    HC_END, HC_START, HC_BAD, HC_OTHER: begin
                        abort     = 1'b1;
                        state_nxt = ST_HUNT;
                    end
                    default: ;
                endcase
            end
            ST_CRC: begin
                case (cls)
                    HC_DATA: begin
                        crc_seen  = 1'b1;
                        state_nxt = ST_HUNT;
                    end
                    HC_END, HC_START, HC_BAD, HC_OTHER: begin
                        abort     = 1'b1;
                        state_nxt = ST_HUNT;
                    end
                    default: ;
                endcase
            end
            default: state_nxt = ST_HUNT;
        endcase
    end

    assign word_data = {half, lo_hold};

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // Low-half holding register, loaded by the first data halfword of a word.
    always_ff @(posedge clk) begin
        if (!rst_n)                             lo_hold <= '0;
        else if (state == ST_LOW && cls == HC_DATA) lo_hold <= half;
    end

    // Flow-control characters leave the framing state untouched.
    assert_ctl_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == HC_XON || cls == HC_XOFF) |=> state == $past(state));

    // Idle characters leave the framing state untouched.
    assert_idle_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == HC_IDLE) |=> state == $past(state));
endmodule

// File: rtl/lnk_out_stage.sv
// Module: pending-word register plus output register with valid/ready.
// Holds the newest word until it is known whether it closes the packet,
// then moves it to the output register; drops a word if that register is
// full and stalled, flagging the overrun.
module lnk_out_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pkt,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_in,
    input  logic              crc_seen,
    input  logic              crc_ok,
    input  logic              abort,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              overrun
);
    logic              pend_v, pend_sop, first_word;
    logic [WORD_W-1:0] pend_data;
    logic              emit, emit_eop, emit_err, can_load;

    assign emit     = pend_v && (word_done || crc_seen || abort);
    assign emit_eop = crc_seen || abort;
    assign emit_err = abort || (crc_seen && !crc_ok);
    assign can_load = !out_valid || out_ready;
    assign overrun  = emit && !can_load;

    // Pending-word register and first-word tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_sop   <= 1'b0;
            pend_data  <= '0;
            first_word <= 1'b0;
        end else if (start_pkt) begin
            pend_v     <= 1'b0;
            first_word <= 1'b1;
        end else if (word_done) begin
            pend_v     <= 1'b1;
            pend_data  <= word_in;
            pend_sop   <= first_word;
            first_word <= 1'b0;
        end else if (crc_seen || abort) begin
            pend_v <= 1'b0;
        end
    end

    // Output register with valid/ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
        end else if (emit && can_load) begin
            out_valid <= 1'b1;
            out_data  <= pend_data;
            out_sop   <= pend_sop;
            out_eop   <= emit_eop;
            out_err   <= emit_err;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // A stalled output word must not change.
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_sop) && $stable(out_eop) &&
                                       $stable(out_err)));

    // The error flag only ever rides on a closing word.
    assert_err_on_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_eop);
endmodule

// File: rtl/link_deframer.sv
// Module: top of the serial link deframer. Wires the character decoder,
// framing FSM, CRC register and output stage, and owns the flow-control
// pulses and the sticky link error flag.
// Assumes one halfword per clock with no gaps; idles fill unused slots.
module link_deframer #(
    parameter int          HALF_W   = 16,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_INIT = 16'hFFFF,
    localparam int         WORD_W   = 2*HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] rx_half,
    input  logic              rx_k_lo,
    input  logic              rx_k_hi,
    input  logic              err_clear,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_crc_err,
    output logic              xon_rcvd,
    output logic              xoff_rcvd,
    output logic              link_error
);
    import lnk_deframer_pkg::*;

    hw_class_e         cls;
    logic              start_pkt, crc_update, word_done, crc_seen, abort, overrun;
    logic [WORD_W-1:0] word_data;
    logic [HALF_W-1:0] crc_q;

    lnk_char_decode #(.HALF_W(HALF_W)) u_decode (
        .half (rx_half),
        .k_lo (rx_k_lo),
        .k_hi (rx_k_hi),
        .cls  (cls)
    );

    lnk_frame_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cls        (cls),
        .half       (rx_half),
        .start_pkt  (start_pkt),
        .crc_update (crc_update),
        .word_done  (word_done),
        .word_data  (word_data),
        .crc_seen   (crc_seen),
        .abort      (abort)
    );

    lnk_crc16 #(.CRC_W(HALF_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_pkt),
        .update  (crc_update),
        .din     (rx_half),
        .crc_q   (crc_q)
    );

    lnk_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pkt (start_pkt),
        .word_done (word_done),
        .word_in   (word_data),
        .crc_seen  (crc_seen),
        .crc_ok    (rx_half == crc_q),
        .abort     (abort),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_crc_err),
        .overrun   (overrun)
    );

    // Flow-control pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xon_rcvd  <= 1'b0;
            xoff_rcvd <= 1'b0;
        end else begin
            xon_rcvd  <= (cls == HC_XON);
            xoff_rcvd <= (cls == HC_XOFF);
        end
    end

    // Sticky link error: faults and overruns set it, err_clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          link_error <= 1'b0;
        else if (cls == HC_BAD || overrun)   link_error <= 1'b1;
        else if (err_clear)                  link_error <= 1'b0;
    end

    // Every packet start must reload the CRC register with its seed.
    assert_crc_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pkt |=> crc_q == CRC_INIT);

    // A flow-control pulse always traces back to its character.
    assert_xon_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xon_rcvd |-> $past(cls == HC_XON));
    assert_xoff_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_rcvd |-> $past(cls == HC_XOFF));

    // link_error holds unless cleared with no new fault.
    assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_error && !err_clear) |=> link_error);
endmodule

// File: tb/link_deframer_test.sv
// Directed bench for link_deframer: each task drives one scenario and checks
// the recovered stream, pulses and error flag against its own expectations.
module link_deframer_test;
    localparam logic [7:0] T_START = 8'hDC, T_END = 8'h9C, T_XON = 8'h5C,
                           T_XOFF = 8'h7C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_half = 16'hBCC5;
    logic        rx_k_lo = 1'b0, rx_k_hi = 1'b1;
    logic        err_clear = 1'b0, out_ready = 1'b1;
    logic        out_valid, out_sop, out_eop, out_crc_err;
    logic        xon_rcvd, xoff_rcvd, link_error;
    logic [31:0] out_data;

    int n_checks = 0, n_fail = 0, n_xon = 0, n_xoff = 0, cycles = 0;
    logic [34:0] exp_q[$];
    logic [34:0] got_q[$];

    always #4 clk = ~clk;

    link_deframer uut (
        .clk(clk), .rst_n(rst_n), .rx_half(rx_half), .rx_k_lo(rx_k_lo),
        .rx_k_hi(rx_k_hi), .err_clear(err_clear), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_crc_err(out_crc_err), .xon_rcvd(xon_rcvd),
        .xoff_rcvd(xoff_rcvd), .link_error(link_error)
    );

    // Monitor at the falling edge: record accepted words and count pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) got_q.push_back({out_data, out_sop, out_eop, out_crc_err});
            if (xon_rcvd)  n_xon++;
            if (xoff_rcvd) n_xoff++;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected <= 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            logic m;
            m = r[15] ^ d[b];
            r = r << 1;
            if (m) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic put_half(input logic [15:0] h, input logic khi, input logic klo);
        @(posedge clk);
        #2;
        rx_half = h; rx_k_hi = khi; rx_k_lo = klo;
    endtask
    task automatic put_data(input logic [15:0] h); put_half(h, 1'b0, 1'b0); endtask
    task automatic put_idle(); put_half(16'hBCC5, 1'b1, 1'b0); endtask
    task automatic put_ctl(input logic [7:0] c); put_half({c, c}, 1'b1, 1'b1); endtask
    task automatic idles(input int n); for (int i = 0; i < n; i++) put_idle(); endtask

    // Compare the recovered stream with the expected queue, then clear both.
    task automatic check_stream(input string req);
        idles(6);
        chk(got_q.size() == exp_q.size(), {req, " word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], {req, " word"}, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
    endtask

    // Send a full packet; optionally idles before low halves and a bad CRC.
    task automatic send_pkt(input logic [31:0] w[], input bit with_idles, input bit corrupt);
        logic [15:0] c = 16'hFFFF;
        put_ctl(T_START);
        foreach (w[i]) begin
            if (with_idles) put_idle();
            put_data(w[i][15:0]);  c = ref_crc(c, w[i][15:0]);
            put_data(w[i][31:16]); c = ref_crc(c, w[i][31:16]);
            exp_q.push_back({w[i], i == 0, i == w.size()-1, corrupt && i == w.size()-1});
        end
        put_ctl(T_END);
        put_data(corrupt ? (c ^ 16'h0040) : c);
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(link_error == 0, "R1 link_error", link_error, 0);
        chk(xon_rcvd == 0 && xoff_rcvd == 0, "R1 pulses", {xon_rcvd, xoff_rcvd}, 0);
    endtask

    task automatic t_basic();
        send_pkt('{32'h1234_5678, 32'hDEAD_BEEF, 32'h0BAD_F00D}, 0, 0);
        check_stream("R2 R4 basic packet");
        send_pkt('{32'hCAFE_0001}, 0, 0);
        check_stream("R4 single word packet");
    endtask

    task automatic t_idles();
        send_pkt('{32'hA5A5_0000, 32'h0000_5A5A, 32'hFFFF_0001, 32'h8000_7FFF}, 1, 0);
        check_stream("R3 idles inside packet");
    endtask

    task automatic t_bad_crc();
        send_pkt('{32'h1111_2222, 32'h3333_4444}, 0, 1);
        check_stream("R5 corrupted CRC");
    endtask

    task automatic t_flow();
        logic [15:0] c = 16'hFFFF;
        int x0 = n_xon, f0 = n_xoff;
        put_ctl(T_START);
        put_data(16'h0102); c = ref_crc(c, 16'h0102);
        put_ctl(T_XON);
        put_data(16'h0304); c = ref_crc(c, 16'h0304);
        put_ctl(T_XOFF);
        put_data(16'h0506); c = ref_crc(c, 16'h0506);
        put_data(16'h0708); c = ref_crc(c, 16'h0708);
        put_ctl(T_XON);
        put_ctl(T_END);
        put_ctl(T_XOFF);
        put_data(c);
        exp_q.push_back({32'h0304_0102, 1'b1, 1'b0, 1'b0});
        exp_q.push_back({32'h0708_0506, 1'b0, 1'b1, 1'b0});
        check_stream("R6 flow control inside packet");
        chk(n_xon - x0 == 2, "R6 xon pulse count", n_xon - x0, 2);
        chk(n_xoff - f0 == 2, "R6 xoff pulse count", n_xoff - f0, 2);
        put_ctl(T_XON); put_ctl(T_XON); idles(3);
        chk(n_xon - x0 == 4, "R6 back-to-back xon", n_xon - x0, 4);
    endtask

    task automatic t_aborts();
        // End after only a low half.
        put_ctl(T_START);
        put_data(16'h0001); put_data(16'h1000);
        put_data(16'h0002); put_data(16'h2000);
        put_data(16'h0003); put_ctl(T_END);
        exp_q.push_back({32'h1000_0001, 1'b1, 1'b0, 1'b0});
        exp_q.push_back({32'h2000_0002, 1'b0, 1'b1, 1'b1});
        put_data(16'h5555); put_data(16'h6666); put_ctl(T_END); put_data(16'h7777);
        check_stream("R7 end after low half, R9 tail ignored");
        // Start inside a packet.
        put_ctl(T_START);
        put_data(16'hAAAA); put_data(16'hBBBB);
        put_ctl(T_START);
        exp_q.push_back({32'hBBBB_AAAA, 1'b1, 1'b1, 1'b1});
        put_data(16'h1234); put_data(16'h5678);
        check_stream("R7 start inside packet");
        // Fault byte inside a packet.
        put_ctl(T_START);
        put_data(16'hC0DE); put_data(16'hF00D);
        put_data(16'h0042);
        put_half(16'h00C5, 1'b1, 1'b0);
        exp_q.push_back({32'hF00D_C0DE, 1'b1, 1'b1, 1'b1});
        check_stream("R7 fault inside packet");
        chk(link_error == 1, "R8 link_error set by fault", link_error, 1);
        // Recovery after aborts.
        send_pkt('{32'h7654_3210}, 0, 0);
        check_stream("R7 recovery packet");
    endtask

    task automatic t_link_err();
        err_clear = 1'b1; put_idle(); err_clear = 1'b0; put_idle();
        chk(link_error == 0, "R8 cleared", link_error, 0);
        put_half(16'hFFFF, 1'b1, 1'b1);
        put_idle(); put_idle();
        chk(link_error == 1, "R8 loss of signal outside packet", link_error, 1);
        err_clear = 1'b1;
        put_half(16'hBCFF, 1'b1, 1'b1);
        put_idle();
        chk(link_error == 1, "R8 fault wins over clear", link_error, 1);
        put_idle(); err_clear = 1'b0; put_idle();
        chk(link_error == 0, "R8 cleared again", link_error, 0);
        idles(2);
        chk(link_error == 0, "R8 stays clear", link_error, 0);
    endtask

    task automatic t_hunt();
        put_data(16'h1111); put_data(16'h2222); put_ctl(T_END); put_data(16'h3333);
        put_data(16'h4444); put_half(16'h12AB, 1'b1, 1'b1);
        check_stream("R9 data while hunting");
    endtask

    task automatic t_empty();
        put_ctl(T_START); put_idle(); put_ctl(T_END); put_data(16'hFFFF);
        check_stream("R11 empty packet");
    endtask

    task automatic t_stall();
        out_ready = 1'b0;
        send_pkt('{32'h9876_5432}, 0, 0);
        idles(2);
        chk(out_valid == 1, "R10 valid while stalled", out_valid, 1);
        idles(4);
        chk(out_valid == 1 && out_data == 32'h9876_5432 && out_eop == 1,
            "R10 word held", out_data, 32'h9876_5432);
        chk(got_q.size() == 0, "R10 nothing accepted", got_q.size(), 0);
        out_ready = 1'b1;
        check_stream("R10 drained after stall");
        chk(out_valid == 0, "R10 valid drops after accept", out_valid, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] w[] = '{32'h0000_00A1, 32'h0000_00B2, 32'h0000_00C3};
        out_ready = 1'b0;
        send_pkt(w, 0, 0);
        exp_q.delete();
        exp_q.push_back({32'h0000_00A1, 1'b1, 1'b0, 1'b0});
        idles(2);
        chk(link_error == 1, "R12 overrun sets link_error", link_error, 1);
        out_ready = 1'b1;
        check_stream("R12 dropped words");
        err_clear = 1'b1; put_idle(); err_clear = 1'b0; put_idle();
    endtask

    initial begin
        idles(4);
        rst_n = 1'b1;
        put_idle();
        t_reset();
        t_basic();
        t_idles();
        t_bad_crc();
        t_flow();
        t_aborts();
        t_link_err();
        t_hunt();
        t_empty();
        t_stall();
        t_overrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule